// File: doc/BRIEF.md
# Auto-ranging sample clock prescaler

This block derives the internal timing of a voiceband codec from whatever master clock the board supplies. It runs on the master clock. In every transmit frame sync period it counts the master clock cycles and matches the count against a table of supported master clock rates. From the matched rate it takes a nominal cycles-per-frame value. That value drives a fractional accumulator. The accumulator emits a 256 kHz oversampling strobe, 32 pulses per frame, and an 8 kHz sample strobe. Both strobes are realigned on each rising edge of transmit frame sync.

The same block also controls power. If both frame sync inputs stay low for longer than the longest supported frame, the block drops to standby. The power-up pin forces standby while it is low. After wake-up, the PCM transmit output enable stays off until two more transmit frame sync periods have passed.

Top module: `psc_prescaler`

## Requirements
- R1: Rate codes follow the list order 256, 512, 1536, 1544, 2048, 2560, 4096, 4800 kHz, giving codes 0 to 7 with nominal counts of rate/8 cycles per frame. A measured period matches the entry nearest to it, and only when it lies within 1 cycle of that entry.
- R2: `rate_code_o` changes only on the clock that takes in a transmit frame sync rising edge. It changes only when that period and the one before it both matched the same entry.
- R3: A measured period that matches no entry sets `rate_fault_o` and leaves `rate_code_o` unchanged. The next period that does match clears the flag.
- R4: When the frame period equals the nominal count of the selected code, exactly 32 oversampling strobes fall in each frame. The m-th strobe comes ceil(m·N/32) cycles after the frame start, and a frame never carries more than 32.
- R5: One cycle after the clock that sees a transmit frame sync rising edge, the sample strobe and an oversampling strobe both pulse for one cycle.
- R6: A transmit frame sync rising edge restarts the oversampling sequence at once, even in the middle of a frame.
- R7: When both frame sync inputs have been low for 602 consecutive cycles, the block enters standby and drops the output enable. Pulses on either input alone keep it out of standby.
- R8: While `pwr_up_i` is low the block sits in standby, and it reaches standby on the clock after the pin falls.
- R9: From standby with `pwr_up_i` high, a transmit frame sync edge starts wake-up. `pcm_tx_oe_o` rises on the clock of the second transmit edge after that one.
- R10: After reset the block is in standby, the output enable is low, no strobes are active, the rate code is 0 and the fault flag is clear.
- R11: No strobe is issued while the block has been in standby for the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_tx_i | input | 1 | Transmit frame sync, synchronous to clk |
| fs_rx_i | input | 1 | Receive frame sync, synchronous to clk |
| pwr_up_i | input | 1 | Power-up request, high to run |
| os_strobe_o | output | 1 | 256 kHz oversampling strobe |
| smp_strobe_o | output | 1 | 8 kHz sample strobe |
| rate_code_o | output | 3 | Selected master clock rate code |
| rate_fault_o | output | 1 | Last measured period matched no rate |
| standby_o | output | 1 | Block is in low-power standby |
| pcm_tx_oe_o | output | 1 | Output enable for the PCM transmit pin |

## Verification
Several properties are checked on every cycle:
- the rate code moves only at a frame edge, and only after a matching confirmation;
- a fault never coincides with a code change;
- the accumulator stays below the nominal count, and the per-frame strobe count stays capped;
- the sample strobe always pairs with an oversampling strobe;
- the power-pin and loss transitions land in standby on the next clock;
- the output enable rises only on a transmit edge;
- no strobe follows a standby cycle.

Other behaviour needs the bench's scenarios:
- that the correct code is chosen for exact and off-by-one periods, including the non-multiple counts 193 and 600;
- that a frame really carries exactly 32 strobes;
- that an early edge restarts the sequence;
- that the enable appears after exactly two further frames.

// File: rtl/psc_pkg.sv
package psc_pkg;

  localparam int NUM_RATES    = 8;
  localparam int FRAME_KHZ    = 8;
  localparam int OS_PER_FRAME = 32;
  localparam int CODE_W       = $clog2(NUM_RATES);
  localparam int PER_W        = 11;

  typedef logic [CODE_W-1:0] rate_code_t;

  typedef enum logic [1:0] {
    PWR_STANDBY = 2'd0,
    PWR_WAKE    = 2'd1,
    PWR_ACTIVE  = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic       hit;
    rate_code_t code;
  } rate_match_t;

  // supported master clock rates in kHz, index = rate code
  function automatic int rate_khz(input int i);
    case (i)
      0:       return 256;
      1:       return 512;
      2:       return 1536;
      3:       return 1544;
      4:       return 2048;
      5:       return 2560;
      6:       return 4096;
      default: return 4800;
    endcase
  endfunction

  function automatic int nominal_count(input int i);
    return rate_khz(i) / FRAME_KHZ;
  endfunction

  function automatic int max_nominal();
    int m;
    m = 0;
    for (int i = 0; i < NUM_RATES; i++)
      if (nominal_count(i) > m) m = nominal_count(i);
    return m;
  endfunction

  // nearest table entry within tol cycles
  function automatic rate_match_t match_period(input logic [PER_W-1:0] per, input int tol);
    rate_match_t r;
    int best;
    int d;
    r.hit  = 1'b0;
    r.code = '0;
    best   = tol + 1;
    for (int i = 0; i < NUM_RATES; i++) begin
      d = int'(per) - nominal_count(i);
      if (d < 0) d = -d;
      if (d < best) begin
        best   = d;
        r.hit  = 1'b1;
        r.code = CODE_W'(i);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/psc_period_meter.sv
module psc_period_meter
  import psc_pkg::*;
#(
  parameter int TOL        = 1,
  parameter int RESET_CODE = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_tx_i,
  input  logic       loss_hit_i,
  output logic       fs_edge_o,
  output rate_code_t rate_code_o,
  output logic       rate_fault_o
);

  logic             fs_q;
  logic [PER_W-1:0] per_q;
  logic             have_q;
  logic             prev_ok_q;
  rate_code_t       prev_code_q;
  rate_code_t       code_q;
  logic             fault_q;

  rate_match_t      m_now;
  logic             measure;
  logic             confirm;

  assign fs_edge_o = fs_tx_i & ~fs_q;
  assign m_now     = match_period(per_q, TOL);
  assign measure   = fs_edge_o & have_q & ~loss_hit_i;
  assign confirm   = measure & m_now.hit & prev_ok_q & (prev_code_q == m_now.code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q        <= 1'b0;
      per_q       <= '0;
      have_q      <= 1'b0;
      prev_ok_q   <= 1'b0;
      prev_code_q <= '0;
      code_q      <= CODE_W'(RESET_CODE);
      fault_q     <= 1'b0;
    end else begin
      fs_q <= fs_tx_i;
      if (fs_edge_o)
        per_q <= PER_W'(1);
      else if (per_q != '1)
        per_q <= per_q + PER_W'(1);

      if (fs_edge_o)
        have_q <= 1'b1;
      else if (loss_hit_i)
        have_q <= 1'b0;

      if (measure) begin
        if (m_now.hit) begin
          fault_q     <= 1'b0;
          prev_ok_q   <= 1'b1;
          prev_code_q <= m_now.code;
          if (confirm) code_q <= m_now.code;
        end else begin
          fault_q   <= 1'b1;
          prev_ok_q <= 1'b0;
        end
      end
    end
  end

  assign rate_code_o  = code_q;
  assign rate_fault_o = fault_q;

  p_code_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $past(fs_edge_o));

  p_code_confirmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> ($past(prev_ok_q) && $past(prev_code_q) == code_q));

  p_fault_holds_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $stable(code_q));

endmodule

// File: rtl/psc_strobe_gen.sv
module psc_strobe_gen
  import psc_pkg::*;
#(
  parameter int NOM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_edge_i,
  input  logic             enable_i,
  input  logic [NOM_W-1:0] nominal_i,
  output logic             os_o,
  output logic             smp_o
);

  localparam int ACC_W  = NOM_W + 1;
  localparam int NSTR_W = $clog2(OS_PER_FRAME + 1);

  logic [ACC_W-1:0]  acc_q;
  logic [NSTR_W-1:0] nstr_q;
  logic [ACC_W-1:0]  acc_sum;
  logic              room;
  logic              tick;

  assign acc_sum = acc_q + ACC_W'(OS_PER_FRAME);
  assign room    = nstr_q < NSTR_W'(OS_PER_FRAME);
  assign tick    = room && (acc_sum >= ACC_W'(nominal_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      nstr_q <= NSTR_W'(OS_PER_FRAME);
      os_o   <= 1'b0;
      smp_o  <= 1'b0;
    end else if (fs_edge_i) begin
      acc_q  <= '0;
      nstr_q <= NSTR_W'(1);
      os_o   <= enable_i;
      smp_o  <= enable_i;
    end else begin
      smp_o <= 1'b0;
      os_o  <= tick & enable_i;
      if (tick) begin
        acc_q  <= acc_sum - ACC_W'(nominal_i);
        nstr_q <= nstr_q + NSTR_W'(1);
      end else if (room) begin
        acc_q <= acc_sum;
      end
    end
  end

  p_strobe_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nstr_q <= NSTR_W'(OS_PER_FRAME));

  p_acc_below_nominal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    room |-> (acc_q < ACC_W'(nominal_i)));

  p_smp_pairs_os_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_o |-> os_o);

endmodule

// File: rtl/psc_power_ctl.sv
module psc_power_ctl
  import psc_pkg::*;
#(
  parameter int WAKE_FRAMES = 2,
  parameter int LOSS_LIMIT  = 602
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_tx_i,
  input  logic fs_rx_i,
  input  logic fs_edge_i,
  input  logic pwr_up_i,
  output logic loss_hit_o,
  output logic standby_o,
  output logic tx_oe_o
);

  localparam int LOSS_W = $clog2(LOSS_LIMIT + 1);
  localparam int WK_W   = $clog2(WAKE_FRAMES + 1);

  logic [LOSS_W-1:0] loss_q;
  logic [WK_W-1:0]   wk_q;
  pwr_state_e        st_q;
  pwr_state_e        st_d;
  logic [WK_W-1:0]   wk_d;

  assign loss_hit_o = (loss_q == LOSS_W'(LOSS_LIMIT));

  always_comb begin
    st_d = st_q;
    wk_d = wk_q;
    unique case (st_q)
      PWR_STANDBY: begin
        if (pwr_up_i && fs_edge_i) begin
          st_d = PWR_WAKE;
          wk_d = '0;
        end
      end
      PWR_WAKE: begin
        if (!pwr_up_i || loss_hit_o) begin
          st_d = PWR_STANDBY;
        end else if (fs_edge_i) begin
          if (wk_q == WK_W'(WAKE_FRAMES - 1)) st_d = PWR_ACTIVE;
          else                                wk_d = wk_q + WK_W'(1);
        end
      end
      default: begin
        if (!pwr_up_i || loss_hit_o) st_d = PWR_STANDBY;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loss_q <= '0;
      wk_q   <= '0;
      st_q   <= PWR_STANDBY;
    end else begin
      if (fs_tx_i || fs_rx_i)
        loss_q <= '0;
      else if (!loss_hit_o)
        loss_q <= loss_q + LOSS_W'(1);
      wk_q <= wk_d;
      st_q <= st_d;
    end
  end

  assign standby_o = (st_q == PWR_STANDBY);
  assign tx_oe_o   = (st_q == PWR_ACTIVE);

  p_loss_to_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_hit_o && !standby_o) |=> standby_o);

  p_pin_low_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up_i |=> standby_o);

  p_oe_on_tx_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe_o) |-> $past(fs_edge_i));

endmodule

// File: rtl/psc_prescaler.sv
module psc_prescaler
  import psc_pkg::*;
#(
  parameter int TOL         = 1,
  parameter int RESET_CODE  = 0,
  parameter int WAKE_FRAMES = 2,
  parameter int LOSS_MARGIN = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fs_tx_i,
  input  logic                    fs_rx_i,
  input  logic                    pwr_up_i,
  output logic                    os_strobe_o,
  output logic                    smp_strobe_o,
  output logic [psc_pkg::CODE_W-1:0] rate_code_o,
  output logic                    rate_fault_o,
  output logic                    standby_o,
  output logic                    pcm_tx_oe_o
);

  localparam int MAX_NOM    = max_nominal();
  localparam int NOM_W      = $clog2(MAX_NOM + 1);
  localparam int LOSS_LIMIT = MAX_NOM + LOSS_MARGIN;

  logic             fs_edge;
  logic             loss_hit;
  rate_code_t       code;
  logic [NOM_W-1:0] nominal;

  assign nominal = NOM_W'(nominal_count(int'(code)));

  psc_period_meter #(.TOL(TOL), .RESET_CODE(RESET_CODE)) u_meter (
    .clk          (clk),
    .rst_n        (rst_n),
    .fs_tx_i      (fs_tx_i),
    .loss_hit_i   (loss_hit),
    .fs_edge_o    (fs_edge),
    .rate_code_o  (code),
    .rate_fault_o (rate_fault_o)
  );

  psc_power_ctl #(.WAKE_FRAMES(WAKE_FRAMES), .LOSS_LIMIT(LOSS_LIMIT)) u_power (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_tx_i    (fs_tx_i),
    .fs_rx_i    (fs_rx_i),
    .fs_edge_i  (fs_edge),
    .pwr_up_i   (pwr_up_i),
    .loss_hit_o (loss_hit),
    .standby_o  (standby_o),
    .tx_oe_o    (pcm_tx_oe_o)
  );

  psc_strobe_gen #(.NOM_W(NOM_W)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_edge_i (fs_edge),
    .enable_i  (~standby_o),
    .nominal_i (nominal),
    .os_o      (os_strobe_o),
    .smp_o     (smp_strobe_o)
  );

  assign rate_code_o = code;

  p_quiet_in_standby_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(standby_o) |-> (!os_strobe_o && !smp_strobe_o));

endmodule

// File: tb/tb_psc_prescaler.sv
module tb_psc_prescaler;

  localparam int CLK_PERIOD = 10;
  localparam int LOSS_LIM   = 602;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs_tx = 1'b0;
  logic       fs_rx = 1'b0;
  logic       pwr_up = 1'b0;
  logic       os_s, smp_s, fault, stby, oe;
  logic [2:0] code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  psc_prescaler dut (
    .clk(clk), .rst_n(rst_n), .fs_tx_i(fs_tx), .fs_rx_i(fs_rx), .pwr_up_i(pwr_up),
    .os_strobe_o(os_s), .smp_strobe_o(smp_s), .rate_code_o(code),
    .rate_fault_o(fault), .standby_o(stby), .pcm_tx_oe_o(oe)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int rates[8] = '{256, 512, 1536, 1544, 2048, 2560, 4096, 4800};
  int m_fsq = 0, m_per = 0, m_have = 0, m_pok = 0, m_pcode = 0, m_code = 0, m_fault = 0;
  int m_acc = 0, m_n = 32, m_os = 0, m_smp = 0, m_loss = 0, m_st = 0, m_wk = 0;
  int e, hit, en, nom, s, found, fcode, nom_j;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fsq = 0; m_per = 0; m_have = 0; m_pok = 0; m_pcode = 0; m_code = 0; m_fault = 0;
      m_acc = 0; m_n = 32; m_os = 0; m_smp = 0; m_loss = 0; m_st = 0; m_wk = 0;
    end else begin
      e   = (fs_tx && !m_fsq) ? 1 : 0;
      hit = (m_loss == LOSS_LIM) ? 1 : 0;
      en  = (m_st != 0) ? 1 : 0;
      nom = rates[m_code] / 8;
      // strobes
      if (e) begin
        m_os = en; m_smp = en; m_acc = 0; m_n = 1;
      end else begin
        m_smp = 0;
        s = m_acc + 32;
        if (m_n < 32 && s >= nom) begin
          m_os = en; m_acc = s - nom; m_n++;
        end else begin
          m_os = 0;
          if (m_n < 32) m_acc = s;
        end
      end
      // measurement: exact entry first, then one cycle off
      if (e && m_have && !hit) begin
        found = 0; fcode = 0;
        foreach (rates[j]) if (!found && rates[j] / 8 == m_per) begin found = 1; fcode = j; end
        foreach (rates[j]) begin
          nom_j = rates[j] / 8;
          if (!found && (m_per == nom_j + 1 || m_per == nom_j - 1)) begin found = 1; fcode = j; end
        end
        if (found) begin
          if (m_pok && m_pcode == fcode) m_code = fcode;
          m_fault = 0; m_pok = 1; m_pcode = fcode;
        end else begin
          m_fault = 1; m_pok = 0;
        end
      end
      if (e) m_per = 1; else if (m_per < 2047) m_per++;
      if (e) m_have = 1; else if (hit) m_have = 0;
      // power
      case (m_st)
        0: if (pwr_up && e) begin m_st = 1; m_wk = 0; end
        1: if (!pwr_up || hit) m_st = 0;
           else if (e) begin if (m_wk == 1) m_st = 2; else m_wk++; end
        default: if (!pwr_up || hit) m_st = 0;
      endcase
      if (fs_tx || fs_rx) m_loss = 0; else if (m_loss < LOSS_LIM) m_loss++;
      m_fsq = fs_tx ? 1 : 0;
    end
  end

  // per-cycle comparison and frame strobe counting
  int os_run = 0, frame_os = -1, os_seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 R6 os strobe", int'(os_s), m_os);
      check("R5 sample strobe", int'(smp_s), m_smp);
      check("R2 rate code", int'(code), m_code);
      check("R3 fault flag", int'(fault), m_fault);
      check("R7 standby", int'(stby), (m_st == 0) ? 1 : 0);
      check("R9 output enable", int'(oe), (m_st == 2) ? 1 : 0);
      if (os_s) os_seen++;
      if (smp_s) begin
        frame_os = os_run;
        os_run = os_s ? 1 : 0;
      end else if (os_s) begin
        os_run++;
      end
    end
  end

  task automatic frames(input int period, input int n, input bit tx, input bit rx);
    for (int f = 0; f < n; f++) begin
      @(negedge clk);
      fs_tx = tx; fs_rx = rx;
      @(negedge clk);
      fs_tx = 1'b0; fs_rx = 1'b0;
      repeat (period - 2) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int seen0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 reset standby", int'(stby), 1);
    check("R10 reset oe", int'(oe), 0);
    check("R10 reset strobes", int'(os_s | smp_s), 0);
    check("R10 reset code", int'(code), 0);
    check("R10 reset fault", int'(fault), 0);

    pwr_up = 1'b1;
    frames(256, 6, 1, 0);
    check("R1 code for 256 cycles", int'(code), 4);
    check("R9 oe after wake", int'(oe), 1);
    check("R4 strobes per frame at 256", frame_os, 32);

    frames(193, 4, 1, 0);
    check("R1 code for 193 cycles", int'(code), 3);
    check("R4 strobes per frame at 193", frame_os, 32);

    frames(600, 4, 1, 0);
    check("R1 code for 600 cycles", int'(code), 7);
    check("R4 strobes per frame at 600", frame_os, 32);

    frames(191, 4, 1, 0);
    check("R1 code for 191 cycles (tolerance)", int'(code), 2);

    // R3 unmatched period
    frames(400, 1, 1, 0);
    frames(191, 1, 1, 0);
    check("R3 fault after 400", int'(fault), 1);
    check("R3 code held", int'(code), 2);
    frames(191, 2, 1, 0);
    check("R3 fault cleared", int'(fault), 0);

    // R2 single odd period does not switch
    frames(64, 1, 1, 0);
    frames(191, 2, 1, 0);
    check("R2 code kept after one odd frame", int'(code), 2);
    frames(64, 4, 1, 0);
    check("R2 code switched after two frames", int'(code), 1);

    // R6 early edge restarts sequence
    frames(256, 4, 1, 0);
    frames(100, 1, 1, 0);
    frames(256, 3, 1, 0);
    check("R6 full frame after early edge", frame_os, 32);

    // R7 receive sync alone keeps running, then total loss
    frames(256, 4, 0, 1);
    check("R7 rx alone no standby", int'(stby), 0);
    repeat (700) @(negedge clk);
    check("R7 standby after loss", int'(stby), 1);
    check("R7 oe dropped", int'(oe), 0);

    // R9 wake sequence
    frames(256, 1, 1, 0);
    check("R9 oe off after first edge", int'(oe), 0);
    frames(256, 1, 1, 0);
    check("R9 oe off after second edge", int'(oe), 0);
    frames(256, 1, 1, 0);
    check("R9 oe on after third edge", int'(oe), 1);

    // R8 pin low, R11 silence
    @(negedge clk);
    pwr_up = 1'b0;
    @(negedge clk);
    check("R8 standby after pin low", int'(stby), 1);
    check("R8 oe low", int'(oe), 0);
    seen0 = os_seen;
    frames(256, 3, 1, 0);
    check("R11 no strobes in standby", os_seen - seen0, 0);

    pwr_up = 1'b1;
    frames(256, 4, 1, 0);
    check("R9 oe after repower", int'(oe), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule